// File: doc/BRIEF.md
# Clock Output Prescaler

This block sits between an already-chosen clock-output source and the pin that drives that clock off chip. A 4-bit divide code, loaded through a synchronous write strobe, either passes the source straight through or divides it by a power of two. The available ratios are 2, 4, 8, 16, 64, 128, 256 and 512. Divide-by-32 is deliberately absent from the set.

Every divided output has a 50% duty cycle. A newly written code is held back until the running output period has finished. This means a live change never produces a shortened high or low phase. The whole block runs in the source clock domain. It is cleared by an asynchronous active-low reset, and the output is held low while that reset is asserted.

Top module: `clkout_prescaler`

## Requirements
- R1: When bit 3 of the active divide code is 0, the output follows the input clock undivided (high while the input is high, low while it is low), for all eight values of bits 2..0.
- R2: Codes 1000, 1001, 1010 and 1011 (bit 3 = 1, bits 2..0 = 0..3) divide the input by 2, 4, 8 and 16.
- R3: Codes 1100, 1101, 1110 and 1111 (bits 2..0 = 4..7) divide the input by 64, 128, 256 and 512, so no code gives divide-by-32.
- R4: Reset leaves the divide code at 0000, so pass-through runs once reset is released.
- R5: A divided output is high for exactly half the ratio in input cycles, then low for exactly half the ratio, beginning each period with its high phase.
- R6: A code written while a divided period runs takes effect only at the end of that period. Every high or low phase is a full half-period of either the old ratio or the new one.
- R7: The output is low for as long as the reset input is low.
- R8: The code register captures the write data on a rising clock edge with the write strobe high; write data without the strobe leaves the code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkSrc | input | 1 | Selected source clock; all logic runs on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Synchronous write strobe for the divide code |
| wrData | input | 4 | Divide code to load when wrEn is high |
| clkOut | output | 1 | Divided or passed-through clock for the output pin |

## Verification
The bench builds the block with its default parameters. These are a 4-bit code and a top exponent of nine, which gives an 8-bit half-period counter. With these values every one of the sixteen codes is reachable, including the 512 ratio that fills the counter and the gap where divide-by-32 would sit. Live code changes are run between slow and fast ratios in both directions. Mid-run resets and a mix of seeded random codes are also applied.

// File: rtl/clkout_prescaler_pkg.sv
package clkout_prescaler_pkg;
  localparam int CODE_W   = 4;
  localparam int MAX_LOG2 = 9;
  localparam int CNT_W    = MAX_LOG2 - 1;
  localparam int SKIP_IDX = 4;

  typedef struct packed {
    logic             restart;
    logic             nextPass;
    logic             passMode;
    logic [CNT_W-1:0] halfMax;
  } presc_strb_t;

  // Ratio is 2^e with e = idx+1, stepping one extra at SKIP_IDX (no /32).
  function automatic logic [CNT_W-1:0] halfMaxOf(input logic [CODE_W-2:0] idx);
    int e;
    e = int'(idx) + 1 + ((int'(idx) >= SKIP_IDX) ? 1 : 0);
    return CNT_W'((1 << (e - 1)) - 1);
  endfunction

  function automatic logic passOf(input logic [CODE_W-1:0] code);
    return !code[CODE_W-1];
  endfunction
endpackage

// File: rtl/clkout_prescaler_ctrl.sv
module clkout_prescaler_ctrl
  import clkout_prescaler_pkg::*;
(
  input  logic              clkSrc,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CODE_W-1:0] wrData,
  input  logic              periodEnd,
  output presc_strb_t       strb,
  output logic [CODE_W-1:0] codeReg,
  output logic [CODE_W-1:0] activeCode,
  output logic              runEn
);

  // Software-visible code register.
  always_ff @(posedge clkSrc or negedge rstN) begin
    if (!rstN) codeReg <= '0;
    else if (wrEn) codeReg <= wrData;
  end

  // Active code only moves on a period boundary.
  always_ff @(posedge clkSrc or negedge rstN) begin
    if (!rstN) begin
      activeCode <= '0;
      runEn      <= 1'b0;
    end else begin
      runEn <= 1'b1;
      if (periodEnd) activeCode <= codeReg;
    end
  end

  always_comb begin
    strb.restart  = periodEnd;
    strb.nextPass = passOf(codeReg);
    strb.passMode = passOf(activeCode);
    strb.halfMax  = halfMaxOf(activeCode[CODE_W-2:0]);
  end
endmodule

// File: rtl/clkout_prescaler_dp.sv
module clkout_prescaler_dp
  import clkout_prescaler_pkg::*;
(
  input  logic             clkSrc,
  input  logic             rstN,
  input  presc_strb_t      strb,
  output logic [CNT_W-1:0] count,
  output logic             divQ,
  output logic             periodEnd
);

  logic atHalf;
  assign atHalf = (count == strb.halfMax);

  always_ff @(posedge clkSrc or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      divQ  <= 1'b0;
    end else if (strb.restart) begin
      count <= '0;
      divQ  <= !strb.nextPass;
    end else if (strb.passMode) begin
      count <= '0;
      divQ  <= 1'b0;
    end else if (atHalf) begin
      count <= '0;
      divQ  <= !divQ;
    end else begin
      count <= count + 1'b1;
    end
  end

  // A period ends after the last cycle of its low phase.
  assign periodEnd = strb.passMode | (!divQ & atHalf);
endmodule

// File: rtl/clkout_prescaler.sv
module clkout_prescaler
  import clkout_prescaler_pkg::*;
(
  input  logic              clkSrc,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CODE_W-1:0] wrData,
  output logic              clkOut
);

  presc_strb_t       strb;
  logic [CODE_W-1:0] codeReg;
  logic [CODE_W-1:0] activeCode;
  logic              runEn;
  logic [CNT_W-1:0]  count;
  logic              divQ;
  logic              periodEnd;

  clkout_prescaler_ctrl u_ctrl (
    .clkSrc    (clkSrc),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .periodEnd (periodEnd),
    .strb      (strb),
    .codeReg   (codeReg),
    .activeCode(activeCode),
    .runEn     (runEn)
  );

  clkout_prescaler_dp u_dp (
    .clkSrc   (clkSrc),
    .rstN     (rstN),
    .strb     (strb),
    .count    (count),
    .divQ     (divQ),
    .periodEnd(periodEnd)
  );

  assign clkOut = strb.passMode ? (clkSrc & runEn) : divQ;
endmodule

// File: rtl/clkout_prescaler_checker.sv
module clkout_prescaler_checker
  import clkout_prescaler_pkg::*;
(
  input logic              clkSrc,
  input logic              rstN,
  input logic              wrEn,
  input logic [CODE_W-1:0] wrData,
  input logic              clkOut,
  input logic [CODE_W-1:0] codeReg,
  input logic [CODE_W-1:0] activeCode,
  input logic              periodEnd,
  input logic              passMode,
  input logic [CNT_W-1:0]  halfMax,
  input logic [CNT_W-1:0]  count,
  input logic              divQ
);

  assert_pass_keeps_div_low_R1: assert property (@(posedge clkSrc) disable iff (!rstN)
    passMode |-> !divQ);

  assert_ratio_pow2_no_32_R3: assert property (@(posedge clkSrc) disable iff (!rstN)
    !passMode |-> ($countones({1'b0, halfMax} + 1'b1) == 1 && halfMax != CNT_W'(15)));

  assert_count_bounded_R5: assert property (@(posedge clkSrc) disable iff (!rstN)
    !passMode |-> (count <= halfMax));

  assert_code_held_mid_period_R6: assert property (@(posedge clkSrc) disable iff (!rstN)
    !$stable(activeCode) |-> $past(periodEnd));

  assert_rise_on_boundary_R6: assert property (@(posedge clkSrc) disable iff (!rstN)
    $rose(divQ) |-> $past(periodEnd));

  assert_out_low_in_reset_R7: assert property (@(negedge clkSrc)
    !rstN |-> !clkOut);

  assert_write_captured_R8: assert property (@(posedge clkSrc) disable iff (!rstN)
    wrEn |=> (codeReg == $past(wrData)));

  assert_no_write_holds_R8: assert property (@(posedge clkSrc) disable iff (!rstN)
    !wrEn |=> $stable(codeReg));
endmodule

bind clkout_prescaler clkout_prescaler_checker u_chk (
  .clkSrc    (clkSrc),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .clkOut    (clkOut),
  .codeReg   (codeReg),
  .activeCode(activeCode),
  .periodEnd (periodEnd),
  .passMode  (strb.passMode),
  .halfMax   (strb.halfMax),
  .count     (count),
  .divQ      (divQ)
);

// File: tb/clkout_prescaler_test.sv
module clkout_prescaler_test;
  logic       clkSrc = 1'b0;
  logic       rstN   = 1'b0;
  logic       wrEn   = 1'b0;
  logic [3:0] wrData = 4'd0;
  logic       clkOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  clkout_prescaler uut (
    .clkSrc(clkSrc), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .clkOut(clkOut)
  );

  always #4 clkSrc = ~clkSrc;

  function automatic int expRatio(input logic [3:0] c);
    int e;
    if (!c[3]) return 1;
    e = (int'(c[2:0]) < 4) ? int'(c[2:0]) + 1 : int'(c[2:0]) + 2;
    return 1 << e;
  endfunction

  function automatic string reqOf(input logic [3:0] c);
    if (!c[3]) return "R1";
    return c[2] ? "R3/R5" : "R2/R5";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishSim();
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clkSrc);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishSim();
    end
  end

  task automatic setCode(input logic [3:0] c);
    @(negedge clkSrc);
    wrEn = 1'b1; wrData = c;
    @(negedge clkSrc);
    wrEn = 1'b0;
  endtask

  task automatic waitRise(output bit ok);
    logic prev, cur;
    ok = 1'b0;
    @(negedge clkSrc); prev = clkOut;
    for (int i = 0; i < 2000 && !ok; i++) begin
      @(negedge clkSrc); cur = clkOut;
      if (!prev && cur) ok = 1'b1;
      prev = cur;
    end
  endtask

  task automatic checkCode(input logic [3:0] c, input string req);
    int  r;
    bit  ok, found;
    logic a, b;
    int  bad, hi, lo;
    r = expRatio(c);
    if (r == 1) begin
      found = 1'b0;
      for (int i = 0; i < 1200 && !found; i++) begin
        @(posedge clkSrc); #2 a = clkOut;
        @(negedge clkSrc); #2 b = clkOut;
        if (a && !b) found = 1'b1;
      end
      check(found, req, int'(found), 1);
      bad = 0;
      for (int i = 0; i < 4; i++) begin
        @(posedge clkSrc); #2 a = clkOut;
        @(negedge clkSrc); #2 b = clkOut;
        if (!(a && !b)) bad++;
      end
      check(bad == 0, req, bad, 0);
    end else begin
      waitRise(ok);
      waitRise(found);
      ok = ok && found;
      check(ok, req, int'(ok), 1);
      hi = 1; lo = 0;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clkSrc);
        if (!clkOut) break;
        hi++;
      end
      lo = 1;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clkSrc);
        if (clkOut) break;
        lo++;
      end
      check(hi == r / 2, req, hi, r / 2);
      check(lo == r / 2, req, lo, r / 2);
    end
  endtask

  // R6: every phase after a live change is a full half of old or new ratio.
  task automatic liveCheck(input logic [3:0] oldC, input logic [3:0] newC, input int gap);
    int hOld, hNew, run, bad, nSamp;
    bit seenNew, first;
    logic prev;
    hOld = expRatio(oldC) / 2;
    hNew = expRatio(newC) / 2;
    setCode(oldC);
    checkCode(oldC, "R6");
    repeat (gap) @(negedge clkSrc);
    setCode(newC);
    nSamp = 2 * expRatio(oldC) + 4 * expRatio(newC);
    bad = 0; seenNew = 1'b0; first = 1'b1; run = 0;
    prev = clkOut;
    for (int i = 0; i < nSamp; i++) begin
      @(negedge clkSrc);
      if (clkOut == prev) run++;
      else begin
        if (!first) begin
          if (run != hOld && run != hNew) bad++;
          if (run == hNew && hNew != hOld) seenNew = 1'b1;
          if (seenNew && run == hOld && hNew != hOld) bad++;
        end
        first = 1'b0;
        run = 1;
        prev = clkOut;
      end
    end
    check(bad == 0 && seenNew, "R6", bad, 0);
  endtask

  initial begin
    int bad;
    int seedSink;
    logic [3:0] c;
    seedSink = $urandom(32'h00C1_0C0D);

    // R7: output low while held in reset.
    bad = 0;
    repeat (3) begin
      @(posedge clkSrc); #2 if (clkOut) bad++;
      @(negedge clkSrc); #2 if (clkOut) bad++;
    end
    check(bad == 0, "R7", bad, 0);
    @(negedge clkSrc); rstN = 1'b1;

    // R4: reset code is pass-through.
    checkCode(4'b0000, "R4");

    // R1 R2 R3 R5: all sixteen codes.
    for (int k = 0; k < 16; k++) begin
      setCode(4'(k));
      checkCode(4'(k), reqOf(4'(k)));
    end

    // R8: data without strobe is ignored.
    setCode(4'b1001);
    checkCode(4'b1001, "R8");
    @(negedge clkSrc); wrData = 4'b1111;
    repeat (20) @(negedge clkSrc);
    wrData = 4'b0010;
    checkCode(4'b1001, "R8");

    // R6: live changes in both directions.
    liveCheck(4'b1010, 4'b1000, 3);
    liveCheck(4'b1000, 4'b1011, 1);
    liveCheck(4'b1011, 4'b1100, 5);
    liveCheck(4'b1101, 4'b1001, 40);

    // Seeded random codes.
    for (int k = 0; k < 10; k++) begin
      c = 4'($urandom % 16);
      setCode(c);
      checkCode(c, reqOf(c));
    end

    // R7 then R4: reset mid-run.
    setCode(4'b1001);
    checkCode(4'b1001, "R2");
    @(negedge clkSrc); #1 rstN = 1'b0;
    bad = 0;
    repeat (4) begin
      @(posedge clkSrc); #2 if (clkOut) bad++;
      @(negedge clkSrc); #2 if (clkOut) bad++;
    end
    check(bad == 0, "R7", bad, 0);
    @(negedge clkSrc); rstN = 1'b1;
    checkCode(4'b0000, "R4");

    finishSim();
  end
endmodule